// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits at the issue stage of an out-of-order core. Instructions that are ready to run arrive one per cycle on an enqueue port. Each one carries a 16-bit sequence number, an operation-class index and a payload tag. The block files each instruction into a small queue for its operation class. Every cycle it then chooses up to a fixed number of instructions to send to the functional units. It always takes the oldest available instruction first, looking across all classes.

Each class queue exposes its oldest entry as its head. A smaller sequence number means an older instruction. The heads of the non-empty queues are ranked by age, and issue slots are filled from that ranking. A class is passed over in any cycle where its functional unit is busy, as shown by its bit in a per-class unit-free vector. At most one instruction per class issues in a cycle, because each class has one unit-free bit. A squash input carries a sequence-number bound. In a single cycle it discards every queued entry younger than that bound.

The issue outputs are combinational and depend only on the stored entries, the unit-free vector and the squash input. An entry shown on an issue slot is taken out of its queue at the next clock edge.

Top module: `issue_selector`

## Requirements
- R1: Each class queue holds at most DEPTH (8) entries. Bit c of `cls_full` is 1 exactly when class c holds 8 entries. An enqueue aimed at a full class is discarded, even if that class issues in the same cycle.
- R2: An entry accepted at a clock edge is not visible on the issue outputs in the cycle of its enqueue. It is eligible from the next cycle. An entry shown on a valid issue slot is removed at the following edge and never shows again.
- R3: Within one class, the entry with the smallest sequence number issues first, whatever order the entries were enqueued in.
- R4: Across classes, slot 0 carries the oldest eligible class head. Each later valid slot carries a strictly larger sequence number than the slot before it.
- R5: At most ISSUE_W (2) slots are valid in a cycle, and no two valid slots carry the same class.
- R6: A class whose `unit_free` bit is 0 issues nothing in that cycle. The next-oldest eligible class head takes the slot instead.
- R7: Valid slots are contiguous from slot 0. If slot 1 is valid, slot 0 is valid too. When two or more classes are eligible, both slots are filled.
- R8: While `squash_valid` is 1, no slot is valid. At that edge every entry with sequence number greater than `squash_bound` (unsigned) is removed. An enqueue in the same cycle is accepted only if its sequence number is at most the bound.
- R9: After reset, all queues are empty, no slot is valid and `cls_full` is 0.

Slot s occupies bits [s*16 +: 16] of `iss_seq`, [s*2 +: 2] of `iss_cls` and [s*8 +: 8] of `iss_tag`. The class is encoded as a binary index from 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_seq | input | 16 | Sequence number of the new entry |
| enq_cls | input | 2 | Operation class of the new entry |
| enq_tag | input | 8 | Payload tag of the new entry |
| unit_free | input | 4 | Per-class functional unit free |
| squash_valid | input | 1 | Squash request |
| squash_bound | input | 16 | Entries with a larger sequence number are discarded |
| iss_valid | output | 2 | Per-slot issue valid |
| iss_seq | output | 32 | Per-slot sequence number |
| iss_cls | output | 4 | Per-slot class |
| iss_tag | output | 16 | Per-slot payload tag |
| cls_full | output | 4 | Per-class queue full |

## Verification
A bench model checks every issue slot in every cycle. Entries arrive in a scrambled sequence order spread over all classes, which separates oldest-first picking within a class from plain arrival order. The queues are then drained while the unit-free vector steps through all 16 masks, once and then again. This shows whether a busy class is skipped, whether the next-oldest head moves up, and whether the valid bits stay packed from slot 0. Issue and enqueue run concurrently, which tests that an entry cannot issue in its own enqueue cycle. Overfilling one class and squashing with enqueues on both sides of the bound cover the cases where an entry must be refused or discarded.

// File: rtl/issue_selector.sv
module issue_selector #(
  parameter int NUM_CLS = 4,
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 16,
  parameter int TAG_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enq_valid,
  input  logic [SEQ_W-1:0]           enq_seq,
  input  logic [$clog2(NUM_CLS)-1:0] enq_cls,
  input  logic [TAG_W-1:0]           enq_tag,
  input  logic [NUM_CLS-1:0]         unit_free,
  input  logic                       squash_valid,
  input  logic [SEQ_W-1:0]           squash_bound,
  output logic [ISSUE_W-1:0]         iss_valid,
  output logic [ISSUE_W*SEQ_W-1:0]   iss_seq,
  output logic [ISSUE_W*$clog2(NUM_CLS)-1:0] iss_cls,
  output logic [ISSUE_W*TAG_W-1:0]   iss_tag,
  output logic [NUM_CLS-1:0]         cls_full
);
  localparam int CW = $clog2(NUM_CLS);
  localparam int DW = $clog2(DEPTH);

  logic [DEPTH-1:0] ent_v   [NUM_CLS];
  logic [SEQ_W-1:0] ent_seq [NUM_CLS][DEPTH];
  logic [TAG_W-1:0] ent_tag [NUM_CLS][DEPTH];

  logic [NUM_CLS-1:0] head_v;
  logic [DW-1:0]      head_idx [NUM_CLS];
  logic [SEQ_W-1:0]   head_seq [NUM_CLS];

  always_comb begin
    for (int c = 0; c < NUM_CLS; c++) begin
      head_v[c]   = 1'b0;
      head_idx[c] = '0;
      head_seq[c] = '1;
      for (int d = 0; d < DEPTH; d++) begin
        if (ent_v[c][d] && (!head_v[c] || ent_seq[c][d] < head_seq[c])) begin
          head_v[c]   = 1'b1;
          head_idx[c] = DW'(d);
          head_seq[c] = ent_seq[c][d];
        end
      end
    end
  end

  logic [NUM_CLS-1:0] taken;
  logic               pick_ok;
  logic [CW-1:0]      pick_c;
  logic [SEQ_W-1:0]   pick_seq;

  always_comb begin
    taken     = '0;
    iss_valid = '0;
    iss_seq   = '0;
    iss_cls   = '0;
    iss_tag   = '0;
    pick_ok   = 1'b0;
    pick_c    = '0;
    pick_seq  = '0;
    for (int s = 0; s < ISSUE_W; s++) begin
      pick_ok  = 1'b0;
      pick_c   = '0;
      pick_seq = '1;
      for (int c = 0; c < NUM_CLS; c++) begin
        if (!squash_valid && head_v[c] && unit_free[c] && !taken[c] &&
            (!pick_ok || head_seq[c] < pick_seq)) begin
          pick_ok  = 1'b1;
          pick_c   = CW'(c);
          pick_seq = head_seq[c];
        end
      end
      if (pick_ok) begin
        taken[pick_c]          = 1'b1;
        iss_valid[s]           = 1'b1;
        iss_seq[s*SEQ_W +: SEQ_W] = pick_seq;
        iss_cls[s*CW +: CW]    = pick_c;
        iss_tag[s*TAG_W +: TAG_W] = ent_tag[pick_c][head_idx[pick_c]];
      end
    end
  end

  logic [DW-1:0] free_idx;
  logic          enq_ok;

  always_comb begin
    free_idx = '0;
    for (int d = DEPTH - 1; d >= 0; d--)
      if (!ent_v[enq_cls][d]) free_idx = DW'(d);
  end

  generate
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_full
      assign cls_full[c] = &ent_v[c];
    end
  endgenerate

  assign enq_ok = enq_valid && !cls_full[enq_cls] &&
                  (!squash_valid || enq_seq <= squash_bound);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CLS; c++) ent_v[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_CLS; c++) begin
        for (int d = 0; d < DEPTH; d++) begin
          if (squash_valid && ent_seq[c][d] > squash_bound) ent_v[c][d] <= 1'b0;
          if (taken[c] && head_idx[c] == DW'(d)) ent_v[c][d] <= 1'b0;
        end
      end
      if (enq_ok) begin
        ent_v[enq_cls][free_idx]   <= 1'b1;
        ent_seq[enq_cls][free_idx] <= enq_seq;
        ent_tag[enq_cls][free_idx] <= enq_tag;
      end
    end
  end

  // R9
  a_reset_idle_chk: assert property (@(posedge clk) $past(!rst_n) |-> (iss_valid == '0 && cls_full == '0));

  // R8
  squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) squash_valid |-> iss_valid == '0);

  // R8
  squash_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(squash_valid) && iss_valid[0] |-> iss_seq[SEQ_W-1:0] <= $past(squash_bound));

  generate
    for (genvar s = 0; s + 1 < ISSUE_W; s++) begin : g_slot_chk
      // R7
      packed_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[s+1] |-> iss_valid[s]);
      // R4
      slot_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[s+1] |-> iss_seq[s*SEQ_W +: SEQ_W] < iss_seq[(s+1)*SEQ_W +: SEQ_W]);
    end
    for (genvar s = 0; s < ISSUE_W; s++) begin : g_free_chk
      // R6
      unit_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[s] |-> unit_free[iss_cls[s*CW +: CW]]);
    end
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_full_chk
      // R1
      full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cls_full[c] && !taken[c] && !squash_valid |=> cls_full[c]);
    end
  endgenerate

  // R5
  one_per_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(taken) == $countones(iss_valid));
endmodule

// File: tb/issue_selector_tb_top.sv
module issue_selector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enq_valid;
  logic [15:0] enq_seq;
  logic [1:0]  enq_cls;
  logic [7:0]  enq_tag;
  logic [3:0]  unit_free;
  logic        squash_valid;
  logic [15:0] squash_bound;
  logic [1:0]  iss_valid;
  logic [31:0] iss_seq;
  logic [3:0]  iss_cls;
  logic [15:0] iss_tag;
  logic [3:0]  cls_full;

  always #5 clk = ~clk;

  issue_selector dut_i (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_seq(enq_seq),
    .enq_cls(enq_cls), .enq_tag(enq_tag), .unit_free(unit_free),
    .squash_valid(squash_valid), .squash_bound(squash_bound),
    .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_cls(iss_cls),
    .iss_tag(iss_tag), .cls_full(cls_full));

  int n_chk = 0;
  int n_fail = 0;
  bit         mv [4][8];
  logic [15:0] ms [4][8];
  logic [7:0]  mt [4][8];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int mcount(input int c);
    int n = 0;
    for (int d = 0; d < 8; d++) if (mv[c][d]) n++;
    return n;
  endfunction

  task automatic cyc(input bit ev, input logic [15:0] es, input logic [1:0] ec,
                     input logic [7:0] et, input logic [3:0] uf,
                     input bit sq, input logic [15:0] sb);
    bit ex_v [2];
    int ex_c [2];
    int ex_d [2];
    bit tk [4];
    bit acc;
    logic [3:0] ex_full;
    enq_valid = ev; enq_seq = es; enq_cls = ec; enq_tag = et;
    unit_free = uf; squash_valid = sq; squash_bound = sb;
    #1;
    for (int c = 0; c < 4; c++) tk[c] = 1'b0;
    for (int s = 0; s < 2; s++) begin
      int bc = -1, bd = 0;
      ex_v[s] = 1'b0;
      if (!sq)
        for (int c = 0; c < 4; c++)
          if (uf[c] && !tk[c])
            for (int d = 0; d < 8; d++)
              if (mv[c][d] && (bc < 0 || ms[c][d] < ms[bc][bd])) begin bc = c; bd = d; end
      if (bc >= 0) begin
        tk[bc] = 1'b1; ex_v[s] = 1'b1; ex_c[s] = bc; ex_d[s] = bd;
      end
    end
    for (int c = 0; c < 4; c++) ex_full[c] = (mcount(c) == 8);
    // R1 full flag, R9 reset state shares this check path
    check(cls_full == ex_full, "R1 cls_full", cls_full, ex_full);
    // R5 width and distinct classes
    check($countones(iss_valid) <= 2 && !(iss_valid == 2'b11 && iss_cls[1:0] == iss_cls[3:2]),
          "R5 slot count/classes", iss_valid, 0);
    for (int s = 0; s < 2; s++) begin
      // R2 R7 R8: validity of each slot
      check(iss_valid[s] == ex_v[s], sq ? "R8 squash no issue" : "R7 R2 slot valid", iss_valid[s], ex_v[s]);
      if (ex_v[s] && iss_valid[s]) begin
        check(iss_seq[s*16 +: 16] == ms[ex_c[s]][ex_d[s]], "R4 R3 slot seq",
              iss_seq[s*16 +: 16], ms[ex_c[s]][ex_d[s]]);
        check(iss_cls[s*2 +: 2] == 2'(ex_c[s]), "R6 slot class", iss_cls[s*2 +: 2], ex_c[s]);
        check(iss_tag[s*8 +: 8] == mt[ex_c[s]][ex_d[s]], "R3 slot tag",
              iss_tag[s*8 +: 8], mt[ex_c[s]][ex_d[s]]);
      end
    end
    acc = ev && !ex_full[ec] && (!sq || es <= sb);
    @(posedge clk);
    if (sq)
      for (int c = 0; c < 4; c++)
        for (int d = 0; d < 8; d++) if (ms[c][d] > sb) mv[c][d] = 1'b0;
    for (int s = 0; s < 2; s++) if (ex_v[s]) mv[ex_c[s]][ex_d[s]] = 1'b0;
    if (acc)
      for (int d = 0; d < 8; d++)
        if (!mv[ec][d]) begin mv[ec][d] = 1'b1; ms[ec][d] = es; mt[ec][d] = et; break; end
    @(negedge clk);
  endtask

  function automatic logic [15:0] sq_of(input int k);
    return 16'((k * 11) % 97 + 1);
  endfunction

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) for (int d = 0; d < 8; d++) mv[c][d] = 1'b0;
    rst_n = 1'b0; enq_valid = 0; enq_seq = 0; enq_cls = 0; enq_tag = 0;
    unit_free = 0; squash_valid = 0; squash_bound = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(iss_valid == 0, "R9 reset valid", iss_valid, 0);
    check(cls_full == 0, "R9 reset full", cls_full, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // scrambled fill, units all busy (R6 nothing issues)
    for (int k = 0; k < 24; k++) cyc(1, sq_of(k), 2'(k % 4), 8'(k), 4'h0, 0, 0);
    cyc(1, sq_of(24), 2'd0, 8'd24, 4'h0, 0, 0);
    cyc(1, sq_of(25), 2'd0, 8'd25, 4'h0, 0, 0);
    // R1: class 0 full now, extra enqueue refused even with issue
    check(cls_full == 4'b0001, "R1 class 0 full", cls_full, 1);
    cyc(1, sq_of(26), 2'd0, 8'd26, 4'h1, 0, 0);
    // drain through every unit mask, twice
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 0, 4'(i % 16), 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 4'hF, 0, 0);
    check(iss_valid == 0, "R2 drained empty", iss_valid, 0);
    // concurrent enqueue and issue (R2)
    for (int k = 30; k < 46; k++) cyc(1, sq_of(k), 2'((k * 3) % 4), 8'(k), 4'(k % 16), 0, 0);
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 0, 4'hF, 0, 0);
    // squash (R8)
    for (int k = 50; k < 70; k++) cyc(1, sq_of(k), 2'(k % 4), 8'(k), 4'h0, 0, 0);
    cyc(1, 16'd3, 2'd2, 8'hA3, 4'hF, 1, 16'd48);
    cyc(1, 16'd200, 2'd1, 8'hC8, 4'hF, 1, 16'd48);
    for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 4'(15 - i), 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 4'hF, 0, 0);
    check(iss_valid == 0, "R8 no squashed entry left", iss_valid, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule